// File: doc/BRIEF.md
# Show-Ahead 32-to-16 Width-Converting FIFO

This block is a single-clock queue that takes 32-bit words on its write side and hands out 16-bit halfwords on its read side. It sits between a DMA engine and a display bus generator, so that every memory word fetched becomes two pixels. Each stored word is read out in two steps: first its low half, then its high half.

The read side is show-ahead. Whenever the queue holds data, the oldest halfword is already present on `rd_data`. A read request only acknowledges that halfword and moves the head on to the next one.

Two fill counts are kept:
- `wr_used` counts 32-bit entries that still hold any unread data.
- `rd_used` counts the remaining halfwords.

Full and empty flags guard both ports. A request that a flag forbids is dropped.

Top module: `pix_halfword_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, and `wr_used` and `rd_used` are both 0.
- R2: While `empty` is 0, `rd_data` equals the oldest unread halfword, with no read request needed. After an accepted read, the next halfword appears on the following cycle.
- R3: For each 32-bit word written, bits [15:0] are delivered first and bits [31:16] second.
- R4: `wr_used` is the number of 32-bit entries still holding at least one unread halfword, in the range 0 to 256. It changes on the clock edge that accepts a write or retires a word.
- R5: `rd_used` equals the number of unread halfwords. This is twice `wr_used`, less one when only the upper half of the head word is left.
- R6: `full` is 1 exactly when `wr_used` is 256, and `empty` is 1 exactly when `rd_used` is 0.
- R7: A write request while `full` is 1 is dropped. The counts and the output data are unchanged by it.
- R8: A read request while `empty` is 0 is acted on, but a read request while `empty` is 1 is dropped. The counts remain 0 and `empty` stays 1.
- R9: A write and a read accepted in the same cycle both take effect. `rd_used` changes by +1 and `wr_used` by 0 or +1, depending on which half was read.
- R10: Halfwords leave in the order their words were written, with no loss and no duplication across the whole depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read request (acknowledges the shown halfword) |
| rd_data | output | 16 | Oldest unread halfword (show-ahead) |
| full | output | 1 | All word entries occupied |
| empty | output | 1 | No halfword left |
| wr_used | output | 9 | Occupied 32-bit entries |
| rd_used | output | 10 | Unread halfwords |

## Verification
Every accepted request takes effect at the next rising edge:
- `full`, `empty`, both counts and `rd_data` all show the new state in the cycle right after that edge.
- Head data is valid in that same cycle, including the cycle after the first write into an empty queue.

The bench drives inputs and compares all outputs on the falling edge. It moves its queue model forward by exactly one accepted step per rising edge, so every expected value refers to the state after the last edge. Directed phases cover these cases:
- reads on an empty queue;
- filling to full, then writing into it;
- draining past empty;
- a long random mix with many simultaneous requests.

// File: rtl/hwfifo_pkg.sv
package hwfifo_pkg;
    // Which half of the head word is currently presented
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/hwfifo_store.sv
module hwfifo_store #(
    parameter int WR_W  = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [WR_W-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [WR_W-1:0] rdata
);
    logic [WR_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read gives show-ahead data straight from storage
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/hwfifo_ctrl.sv
module hwfifo_ctrl
    import hwfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output half_e         half,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] wr_used,
    output logic [CW:0]   rd_used
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        half_e         half;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  rd_fire;
    logic  retire;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign wr_fire = wr_en && !full;
    assign rd_fire = rd_en && !empty;
    assign retire  = rd_fire && (st_q.half == HALF_HI);

    always_comb begin
        st_d = st_q;
        if (wr_fire) begin
            st_d.wptr = st_q.wptr + AW'(1);
        end
        if (rd_fire) begin
            if (st_q.half == HALF_LO) begin
                st_d.half = HALF_HI;
            end else begin
                st_d.half = HALF_LO;
                st_d.rptr = st_q.rptr + AW'(1);
            end
        end
        case ({wr_fire, retire})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wptr: '0, rptr: '0, cnt: '0, half: HALF_LO};
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr   = st_q.wptr;
    assign raddr   = st_q.rptr;
    assign half    = st_q.half;
    assign wr_used = st_q.cnt;
    assign rd_used = {st_q.cnt, 1'b0} - (CW + 1)'(st_q.half == HALF_HI);
endmodule

// File: rtl/pix_halfword_fifo.sv
module pix_halfword_fifo
    import hwfifo_pkg::*;
#(
    parameter int WR_W  = 32,
    parameter int DEPTH = 256,
    localparam int RD_W = WR_W / 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            full,
    output logic            empty,
    output logic [CW-1:0]   wr_used,
    output logic [CW:0]     rd_used
);
    logic            wr_fire;
    logic [AW-1:0]   waddr;
    logic [AW-1:0]   raddr;
    half_e           half;
    logic [WR_W-1:0] head_word;

    hwfifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_fire (wr_fire),
        .waddr   (waddr),
        .raddr   (raddr),
        .half    (half),
        .full    (full),
        .empty   (empty),
        .wr_used (wr_used),
        .rd_used (rd_used)
    );

    hwfifo_store #(.WR_W(WR_W), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (head_word)
    );

    // Low half leaves first, high half second
    assign rd_data = (half == HALF_HI) ? head_word[WR_W-1:RD_W] : head_word[RD_W-1:0];
endmodule

// File: rtl/hwfifo_chk.sv
module hwfifo_chk #(
    parameter int WR_W  = 32,
    parameter int DEPTH = 256,
    localparam int RD_W = WR_W / 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic [RD_W-1:0] rd_data,
    input logic            full,
    input logic            empty,
    input logic [CW-1:0]   wr_used,
    input logic [CW:0]     rd_used
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_used <= CW'(DEPTH)); // R4
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(wr_used) && $stable(rd_data))); // R7
    AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (empty && rd_used == '0)); // R8
    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && rd_en && !wr_en) |=> (rd_used == $past(rd_used) - (CW + 1)'(1))); // R5
    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && wr_en && !rd_en) |=> (rd_used == $past(rd_used) + (CW + 1)'(2))); // R5
    AST_BOTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && !empty && wr_en && rd_en) |=> (rd_used == $past(rd_used) + (CW + 1)'(1))); // R9
    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !rd_en) |=> $stable(rd_data)); // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R6
endmodule

bind pix_halfword_fifo hwfifo_chk #(.WR_W(WR_W), .DEPTH(DEPTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty),
    .wr_used (wr_used),
    .rd_used (rd_used)
);

// File: tb/pix_halfword_fifo_tb_top.sv
module pix_halfword_fifo_tb_top;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        full;
    logic        empty;
    logic [8:0]  wr_used;
    logic [9:0]  rd_used;

    int n_total = 0;
    int n_fail  = 0;
    logic [15:0] model_q[$];
    string ctx = "R1";

    always #2 clk = ~clk;

    pix_halfword_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .wr_used(wr_used), .rd_used(rd_used)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_total++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s (%s): got %0h expected %0h", tag, ctx, got, exp);
        end
    endtask

    // Compare every output against the queue model
    task automatic compare_all();
        int sz = model_q.size();
        int words = (sz + 1) / 2;
        chk("R4 wr_used", int'(wr_used), words);
        chk("R5 rd_used", int'(rd_used), sz);
        chk("R6 full", int'(full), int'(words == DEPTH));
        chk("R6 empty", int'(empty), int'(sz == 0));
        if (sz > 0) chk("R2 R3 R10 rd_data", int'(rd_data), int'(model_q[0]));
    endtask

    // Drive one cycle of stimulus and advance the model by one edge
    task automatic step(input logic w, input logic r);
        int words = (model_q.size() + 1) / 2;
        logic wacc = w && (words < DEPTH);
        logic racc = r && (model_q.size() > 0);
        logic [31:0] d = $urandom;
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        if (racc) void'(model_q.pop_front());
        if (wacc) begin
            model_q.push_back(d[15:0]);
            model_q.push_back(d[31:16]);
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL R10 watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        ctx = "R1";
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 wr_used", int'(wr_used), 0);
        chk("R1 rd_used", int'(rd_used), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        ctx = "R8 read on empty";
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
        ctx = "R3 first word";
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        ctx = "R4 fill";
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0);
        ctx = "R7 write on full";
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
        ctx = "R7 full with reads";
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
        ctx = "R10 drain";
        for (int i = 0; i < 2 * DEPTH + 10; i++) step(1'b0, 1'b1);
        ctx = "R9 random mix";
        for (int i = 0; i < 4000; i++) begin
            logic w = ($urandom % 100) < ((i / 500) % 2 == 0 ? 70 : 35);
            logic r = ($urandom % 100) < ((i / 500) % 2 == 0 ? 45 : 80);
            step(w, r);
        end
        ctx = "R8 final drain";
        for (int i = 0; i < 2 * DEPTH + 4; i++) step(1'b0, 1'b1);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule